// File: doc/BRIEF.md
# Multichannel Decimating Bit-Serial FIR Filter

This block is a decimating finite impulse response filter that serves several interleaved channels with one shared datapath. It uses distributed arithmetic rather than multipliers. Each accepted sample is shifted into the delay line of its own channel. The filter then walks through the sample bits a few positions per clock. Each bit position of all taps forms the address of a precomputed table that holds every partial sum of the coefficients. The table outputs are weighted by their bit position and accumulated, and the sign bit position is subtracted so that two's-complement inputs come out exact.

The number of clocks spent on one sample, N, equals the input width divided by the number of serial units. The sink is a valid/ready stream. The filter lowers `in_ready` while it works on a sample and raises it again in the final work cycle, so that a held-valid source is served once every N clocks. A sample is transferred on a rising clock edge where both `in_valid` and `in_ready` are high. The upstream side must hold `in_data` stable until that edge. While `in_valid` is low, nothing is taken.

Channels are served in a fixed rotation starting at channel 0. A result is emitted only on every M-th pass through all channels, where M is the decimation factor. The source side has no back-pressure: each result is a single-cycle `out_valid` beat. Start-of-group and end-of-group flags mark the results of the first and the last channel. Coefficients are fixed by a parameter: bits `[t*COEF_W +: COEF_W]` hold the signed coefficient of tap t, and tap 0 is the newest sample.

Top module: `fir_da_decim`

## Requirements
- R1: With `in_valid` held high, samples are accepted exactly N = IN_W/UNITS clocks apart; `in_ready` is low for the N-1 clocks after an acceptance and high whenever the filter is idle.
- R2: Input presented while `in_valid` is low is not taken: it changes neither the delay lines nor the channel rotation nor any output.
- R3: Accepted samples go to channels 0, 1, ..., CHANNELS-1 in rotation, restarting at channel 0 after reset; `out_chan` carries the channel index of each result.
- R4: A result equals the exact signed sum over taps t of coefficient t times the t-th most recent sample of that channel (tap 0 the newest), for all two's-complement input values including the most negative, with no overflow in OUT_W bits.
- R5: Counting full passes over all channels from reset, a result is emitted only for samples in pass M-1, 2M-1, ...; no other sample produces output.
- R6: `out_valid` rises N clocks after the edge that accepted the sample and lasts exactly one clock per result.
- R7: `out_sop` is high exactly with the channel 0 result and `out_eop` exactly with the channel CHANNELS-1 result of each group.
- R8: Synchronous reset clears all delay lines, the accumulator, the channel rotation and the decimation count; after reset `out_valid` is low and `in_ready` is high.
- R9: Under continuous input, consecutive group starts (`out_sop`) are N x CHANNELS x M clocks apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sink sample is present |
| in_ready | output | 1 | Filter can take a sample on this edge |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | OUT_W | Signed filter result |
| out_chan | output | CHW | Channel index of the result |
| out_sop | output | 1 | First channel of an output group |
| out_eop | output | 1 | Last channel of an output group |

## Verification
A held-valid ramp through every 8-bit value drives all sign and magnitude combinations through the table addressing. This separates an error in the sign-slice subtraction from one in the shift weights of the lower slices. A run of alternating extreme values then stresses the accumulator range and the handling of the most negative sample, and under continuous flow it also fixes the acceptance spacing and the group period. A sparse pattern with idle gaps and junk data while valid is low shows that data is taken only on valid beats. A reset in the middle of a decimation pass, followed by impulses on each channel, shows that delay lines, rotation and decimation count start over, because the results must then reproduce the bare coefficients.

// File: rtl/fir_da_pkg.sv
package fir_da_pkg;

  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_RUN  = 1'b1
  } eng_state_e;

  // Index width that never collapses to zero bits.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/fir_da_ctrl.sv
module fir_da_ctrl
  import fir_da_pkg::*;
#(
  parameter int N_CLK    = 4,
  parameter int CHANNELS = 2,
  parameter int DECIM    = 2,
  localparam int SW      = idx_w(N_CLK),
  localparam int CHW     = idx_w(CHANNELS),
  localparam int DW      = idx_w(DECIM)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  output logic           accept_o,
  output logic           run_o,
  output logic           first_o,
  output logic           last_o,
  output logic           commit_o,
  output logic [SW-1:0]  step_o,
  output logic [CHW-1:0] wr_ch_o,
  output logic [CHW-1:0] calc_ch_o
);

  eng_state_e     state_q;
  logic [SW-1:0]  step_q;
  logic [CHW-1:0] wr_ch_q;
  logic [CHW-1:0] calc_ch_q;
  logic [DW-1:0]  pass_q;

  assign run_o     = (state_q == ENG_RUN);
  assign last_o    = run_o && (step_q == SW'(N_CLK - 1));
  assign first_o   = run_o && (step_q == '0);
  assign in_ready  = !run_o || last_o;
  assign accept_o  = in_valid && in_ready;
  assign commit_o  = last_o && (pass_q == DW'(DECIM - 1));
  assign step_o    = step_q;
  assign wr_ch_o   = wr_ch_q;
  assign calc_ch_o = calc_ch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ENG_IDLE;
      step_q    <= '0;
      wr_ch_q   <= '0;
      calc_ch_q <= '0;
      pass_q    <= '0;
    end else begin
      if (accept_o) begin
        state_q   <= ENG_RUN;
        step_q    <= '0;
        calc_ch_q <= wr_ch_q;
        wr_ch_q   <= (wr_ch_q == CHW'(CHANNELS - 1)) ? '0 : wr_ch_q + 1'b1;
      end else if (last_o) begin
        state_q <= ENG_IDLE;
      end else if (run_o) begin
        step_q <= step_q + 1'b1;
      end
      if (last_o && (calc_ch_q == CHW'(CHANNELS - 1))) begin
        pass_q <= (pass_q == DW'(DECIM - 1)) ? '0 : pass_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/fir_da_taps.sv
module fir_da_taps #(
  parameter int TAPS     = 4,
  parameter int IN_W     = 8,
  parameter int CHANNELS = 2,
  parameter int CHW      = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [CHW-1:0]         wr_ch,
  input  logic [IN_W-1:0]        wr_data,
  input  logic [CHW-1:0]         rd_ch,
  output logic [TAPS*IN_W-1:0]   rd_taps
);

  localparam int LINE_W = TAPS * IN_W;

  logic [LINE_W-1:0] line_q [CHANNELS];

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    logic [LINE_W-1:0] shifted;
    if (TAPS == 1) begin : g_single
      assign shifted = wr_data;
    end else begin : g_multi
      assign shifted = {line_q[c][LINE_W-IN_W-1:0], wr_data};
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        line_q[c] <= '0;
      end else if (wr_en && (wr_ch == CHW'(c))) begin
        line_q[c] <= shifted;
      end
    end
  end

  assign rd_taps = line_q[rd_ch];

endmodule

// File: rtl/fir_da_rom.sv
module fir_da_rom #(
  parameter int                      TAPS   = 4,
  parameter int                      COEF_W = 8,
  parameter int                      LW     = 10,
  parameter logic [TAPS*COEF_W-1:0]  COEFS  = '0
) (
  input  logic [TAPS-1:0]        addr,
  output logic signed [LW-1:0]   value
);

  localparam int ENTRIES = 1 << TAPS;

  // Partial sum of the coefficients whose tap bit is set in the address.
  function automatic logic signed [LW-1:0] subset_sum(input int sel);
    logic signed [LW-1:0] acc;
    acc = '0;
    for (int t = 0; t < TAPS; t++) begin
      if (sel[t]) acc = acc + LW'($signed(COEFS[t*COEF_W +: COEF_W]));
    end
    return acc;
  endfunction

  logic signed [LW-1:0] table_q [ENTRIES];

  for (genvar a = 0; a < ENTRIES; a++) begin : g_entry
    assign table_q[a] = subset_sum(a);
  end

  assign value = table_q[addr];

endmodule

// File: rtl/fir_da_mac.sv
module fir_da_mac #(
  parameter int UNITS = 2,
  parameter int IN_W  = 8,
  parameter int LW    = 10,
  parameter int AW    = 18,
  parameter int SW    = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run,
  input  logic                    first,
  input  logic [SW-1:0]           step,
  input  logic [UNITS*LW-1:0]     lut_flat,
  output logic signed [AW-1:0]    acc_next
);

  logic signed [AW-1:0] acc_q;
  logic signed [AW-1:0] contrib;
  logic signed [AW-1:0] ext;
  int                   bitpos;

  always_comb begin
    contrib = '0;
    ext     = '0;
    bitpos  = 0;
    for (int u = 0; u < UNITS; u++) begin
      bitpos = int'(step) * UNITS + u;
      ext    = AW'($signed(lut_flat[u*LW +: LW]));
      ext    = ext <<< bitpos;
      // The sign bit slice carries negative weight.
      if (bitpos == IN_W - 1) contrib = contrib - ext;
      else                    contrib = contrib + ext;
    end
    acc_next = (first ? '0 : acc_q) + contrib;
  end

  always_ff @(posedge clk) begin
    if (rst)      acc_q <= '0;
    else if (run) acc_q <= acc_next;
  end

endmodule

// File: rtl/fir_da_decim.sv
module fir_da_decim
  import fir_da_pkg::*;
#(
  parameter int                     TAPS     = 4,
  parameter int                     IN_W     = 8,
  parameter int                     UNITS    = 2,
  parameter int                     CHANNELS = 2,
  parameter int                     DECIM    = 2,
  parameter int                     COEF_W   = 8,
  parameter logic [TAPS*COEF_W-1:0] COEFS    = 32'h8007FB03,
  localparam int                    OUT_W    = IN_W + COEF_W + $clog2(TAPS),
  localparam int                    CHW      = idx_w(CHANNELS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IN_W-1:0]   in_data,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_data,
  output logic [CHW-1:0]    out_chan,
  output logic              out_sop,
  output logic              out_eop
);

  localparam int N_CLK = IN_W / UNITS;
  localparam int SW    = idx_w(N_CLK);
  localparam int LW    = COEF_W + $clog2(TAPS);

  logic                    accept, run, first, last, commit;
  logic [SW-1:0]           step;
  logic [CHW-1:0]          wr_ch, calc_ch;
  logic [TAPS*IN_W-1:0]    taps_flat;
  logic [UNITS*TAPS-1:0]   addr;
  logic [UNITS*LW-1:0]     lut_flat;
  logic signed [OUT_W-1:0] acc_next;

  fir_da_ctrl #(
    .N_CLK(N_CLK), .CHANNELS(CHANNELS), .DECIM(DECIM)
  ) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .accept_o(accept), .run_o(run), .first_o(first), .last_o(last),
    .commit_o(commit), .step_o(step), .wr_ch_o(wr_ch), .calc_ch_o(calc_ch)
  );

  fir_da_taps #(
    .TAPS(TAPS), .IN_W(IN_W), .CHANNELS(CHANNELS), .CHW(CHW)
  ) u_taps (
    .clk(clk), .rst(rst), .wr_en(accept), .wr_ch(wr_ch), .wr_data(in_data),
    .rd_ch(calc_ch), .rd_taps(taps_flat)
  );

  // Unit u handles bit position step*UNITS+u of every tap.
  always_comb begin
    for (int u = 0; u < UNITS; u++) begin
      for (int t = 0; t < TAPS; t++) begin
        addr[u*TAPS + t] = taps_flat[t*IN_W + int'(step)*UNITS + u];
      end
    end
  end

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    fir_da_rom #(
      .TAPS(TAPS), .COEF_W(COEF_W), .LW(LW), .COEFS(COEFS)
    ) u_rom (
      .addr(addr[u*TAPS +: TAPS]),
      .value(lut_flat[u*LW +: LW])
    );
  end

  fir_da_mac #(
    .UNITS(UNITS), .IN_W(IN_W), .LW(LW), .AW(OUT_W), .SW(SW)
  ) u_mac (
    .clk(clk), .rst(rst), .run(run), .first(first), .step(step),
    .lut_flat(lut_flat), .acc_next(acc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_data  <= '0;
      out_chan  <= '0;
    end else begin
      out_valid <= commit;
      out_sop   <= commit && (calc_ch == '0);
      out_eop   <= commit && (calc_ch == CHW'(CHANNELS - 1));
      if (commit) begin
        out_data <= acc_next;
        out_chan <= calc_ch;
      end
    end
  end

endmodule

// File: rtl/fir_da_chk.sv
module fir_da_chk #(
  parameter int N   = 4,
  parameter int CH  = 2,
  parameter int CHW = 1
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           in_ready,
  input logic           out_valid,
  input logic [CHW-1:0] out_chan,
  input logic           out_sop,
  input logic           out_eop
);

  localparam int AGW = $clog2(N + 1);

  logic [AGW-1:0] age_q;

  always_ff @(posedge clk) begin
    if (rst)                        age_q <= AGW'(N);
    else if (in_valid && in_ready)  age_q <= AGW'(1);
    else if (age_q < AGW'(N))       age_q <= age_q + 1'b1;
  end

  p_accept_spacing_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |-> (age_q == AGW'(N)));

  p_ready_drop_r1: assert property (@(posedge clk) disable iff (rst)
    ((N > 1) && in_valid && in_ready) |=> !in_ready);

  p_one_beat_r6: assert property (@(posedge clk) disable iff (rst)
    ((N > 1) && out_valid) |=> !out_valid);

  p_sop_first_r7: assert property (@(posedge clk) disable iff (rst)
    out_sop |-> (out_valid && (out_chan == '0)));

  p_eop_last_r7: assert property (@(posedge clk) disable iff (rst)
    out_eop |-> (out_valid && (out_chan == CHW'(CH - 1))));

  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready));

endmodule

bind fir_da_decim fir_da_chk #(.N(N_CLK), .CH(CHANNELS), .CHW(CHW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_chan(out_chan), .out_sop(out_sop), .out_eop(out_eop)
);

// File: tb/test_fir_da_decim.sv
`timescale 1ns/1ps
module test_fir_da_decim;

  localparam int TAPS = 4, IN_W = 8, UNITS = 2, CH = 2, DECIM = 2, COEF_W = 8;
  localparam int N = IN_W / UNITS;
  localparam int OUT_W = IN_W + COEF_W + $clog2(TAPS);
  localparam logic [TAPS*COEF_W-1:0] COEFS = 32'hFF7F8005; // c0=5 c1=-128 c2=127 c3=-1

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [IN_W-1:0]  in_data = '0;
  logic             in_ready, out_valid, out_sop, out_eop;
  logic [OUT_W-1:0] out_data;
  logic [0:0]       out_chan;

  fir_da_decim #(
    .TAPS(TAPS), .IN_W(IN_W), .UNITS(UNITS), .CHANNELS(CH), .DECIM(DECIM),
    .COEF_W(COEF_W), .COEFS(COEFS)
  ) i_fir_da_decim (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .out_chan(out_chan), .out_sop(out_sop), .out_eop(out_eop)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, n_out = 0;
  int cf [TAPS];
  int hist [CH][TAPS];
  int rr = 0, pass_cnt = 0, last_acc = -1, last_sop = -1, acc_at = 0, y = 0;
  bit stream_mode = 0, done = 0;
  int q_val[$], q_ch[$], q_cyc[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int c = 0; c < CH; c++)
      for (int t = 0; t < TAPS; t++) hist[c][t] = 0;
    rr = 0; pass_cnt = 0; last_acc = -1; last_sop = -1;
    q_val.delete(); q_ch.delete(); q_cyc.delete();
  endtask

  // Input monitor and reference model
  always @(negedge clk) begin
    if (!rst && in_valid && in_ready) begin
      acc_at = cyc + 1;
      if (stream_mode && last_acc >= 0)
        chk((acc_at - last_acc) == N, "R1", "accept spacing", acc_at - last_acc, N);
      last_acc = acc_at;
      for (int t = TAPS - 1; t > 0; t--) hist[rr][t] = hist[rr][t-1];
      hist[rr][0] = int'($signed(in_data));
      y = 0;
      for (int t = 0; t < TAPS; t++) y += cf[t] * hist[rr][t];
      if (pass_cnt == DECIM - 1) begin
        q_val.push_back(y); q_ch.push_back(rr); q_cyc.push_back(acc_at + N);
      end
      if (rr == CH - 1) pass_cnt = (pass_cnt + 1) % DECIM;
      rr = (rr + 1) % CH;
    end
  end

  // Output monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      n_out++;
      if (q_val.size() == 0) begin
        chk(0, "R5", "unexpected output", 1, 0);
      end else begin
        chk($signed(out_data) == q_val[0], "R4", "result value",
            $signed(out_data), q_val[0]);
        chk(int'(out_chan) == q_ch[0], "R3", "channel index", out_chan, q_ch[0]);
        chk(cyc == q_cyc[0], "R6", "latency edge", cyc, q_cyc[0]);
        chk(out_sop == (q_ch[0] == 0), "R7", "sop flag", out_sop, q_ch[0] == 0);
        chk(out_eop == (q_ch[0] == CH - 1), "R7", "eop flag", out_eop, q_ch[0] == CH - 1);
        void'(q_val.pop_front()); void'(q_ch.pop_front()); void'(q_cyc.pop_front());
      end
      if (out_sop) begin
        if (stream_mode && last_sop >= 0)
          chk((cyc - last_sop) == N * CH * DECIM, "R9", "group period",
              cyc - last_sop, N * CH * DECIM);
        last_sop = cyc;
      end
    end
  end

  task automatic send(input logic [IN_W-1:0] v);
    in_valid = 1'b1;
    in_data  = v;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n, input logic [IN_W-1:0] junk);
    in_valid = 1'b0;
    in_data  = junk;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic apply_reset();
    @(posedge clk); #1;
    rst = 1'b1; in_valid = 1'b0;
    model_clear();
    repeat (2) begin @(posedge clk); #1; end
    chk(out_valid == 1'b0, "R8", "out_valid in reset", out_valid, 0);
    chk(in_ready == 1'b1, "R8", "in_ready in reset", in_ready, 1);
    rst = 1'b0;
  endtask

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 100000 && !done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog: actual %0d expected %0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < TAPS; t++) cf[t] = int'($signed(COEFS[t*COEF_W +: COEF_W]));
    model_clear();
    repeat (3) begin @(posedge clk); #1; end
    chk(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R8", "in_ready after reset", in_ready, 1);
    rst = 1'b0;

    // Held-valid sweep over every input code, then alternating extremes
    stream_mode = 1;
    for (int v = -128; v < 128; v++) send(IN_W'(v));
    for (int k = 0; k < 32; k++) send((k % 2 == 0) ? 8'h80 : 8'h7F);
    stream_mode = 0;
    idle(3 * N, 8'h55);
    chk(in_ready == 1'b1, "R1", "ready when idle", in_ready, 1);

    // Sparse traffic with junk while valid is low (R2)
    for (int k = 0; k < 24; k++) begin
      send(IN_W'(k * 37 - 90));
      idle(k % 5 + 1, IN_W'(k * 91));
    end
    idle(2 * N, 8'hA5);
    chk(q_val.size() == 0, "R2", "pending results drained", q_val.size(), 0);

    // Reset in the middle of a decimation pass
    send(8'h7F); send(8'h80); send(8'h11);
    apply_reset();
    // Impulses on each channel after reset (R3, R8)
    send(8'd1); send(8'hFF);
    for (int k = 0; k < 2 * TAPS * CH; k++) send(8'd0);
    idle(4 * N, 8'h3C);
    chk(q_val.size() == 0, "R5", "all expected results seen", q_val.size(), 0);
    chk(n_out > 0, "R5", "results produced", n_out, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule